// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupts

This block is a memory-mapped controller for a parameterised number of general-purpose lines, up to 32. Software reaches it through a plain 32-bit register bus: a write strobe, a read strobe, an 8-bit byte address and write data. Read data is registered and appears the cycle after the read strobe. Each line has a one-bit setting in eight settings words: output value, direction, interrupt enable, interrupt mask, trigger kind, polarity, debounce and dual-edge. Each word has a set address and a clear address, so one line can be changed without a read-modify-write.

Every input passes through a two-flop synchroniser. It then goes through an optional debounce filter that runs on the block clock. The filtered level drives the readable pin-level word and the event logic. Edge events are held until software writes to the acknowledge address. Level events are not held and follow the input. A line counts as pending only when it is enabled and not masked. The pending lines are ORed into one interrupt output, which has its own gate.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every settings word is 0. `pin_oe`, `pin_out` and `irq_out` are 0, and reads of 0x018, 0x0b8 and 0x070 return 0.
- R2: Writing 1s to a set address sets the matching bits and writing 1s to a clear address clears them. Bits written as 0 keep their value. Output value is set at 0x000 and cleared at 0x004 and drives `pin_out`. Direction is set at 0x010 and cleared at 0x014, drives `pin_oe` (1 = output) and reads back at 0x018.
- R3: A read of 0x080 returns the filtered pin levels, bit i for line i.
- R4: When a line's debounce bit is set (set 0x060, clear 0x064), a new level is accepted only after it has held for DB_CYCLES consecutive clock cycles. A shorter pulse leaves the 0x080 bit unchanged.
- R5: With the trigger bit at 1 (set 0x040, clear 0x044), polarity 1 (set 0x050, clear 0x054) selects rising edges and polarity 0 selects falling edges. The event is held in bit i of the status word at 0x070 until it is acknowledged.
- R6: With the trigger bit at 0, polarity 1 makes a high level pending and polarity 0 makes a low level pending. Status follows the level. A write to the acknowledge address has no effect on it.
- R7: A set dual-edge bit (set 0x0b0, clear 0x0b4, read back at 0x0b8) makes the line trigger on both edges, whatever its trigger and polarity bits hold. Clearing the dual-edge bit brings back the trigger and polarity behaviour.
- R8: Writing 1 to bit i of 0x078 clears the held edge event of line i. If a new edge event of that line arrives in the same cycle as the acknowledge, the event stays held.
- R9: Status bit i is 1 only while the enable bit (set 0x020, clear 0x024) is 1 and the mask bit (set 0x030, clear 0x034) is 0. Masking hides a held event without clearing it. A disabled line records no edge events.
- R10: `irq_out` is 1 exactly when some status bit is 1 and the combined gate is open. A write to 0x0a0 with bit 0 = 1 opens the gate, and with bit 0 = 0 closes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the debounce sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, bit i for line i |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NL | Raw pin levels, asynchronous |
| pin_out | output | NL | Output value per line |
| pin_oe | output | NL | Output enable per line (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An acknowledge write and a fresh edge event on the same line can land in the same clock cycle. The bench provokes this by changing the pin exactly three cycles before the acknowledge write is sampled, which is the depth of the synchroniser plus the filter register. It then reads the status word and expects the bit to still be set. Masking or closing the combined gate over a held event is also checked: the event must come back when the mask or gate is released, so hiding an event and clearing it are told apart.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam int NCFG   = 8;

  // settings words; index order is the order of their set/clear address pairs
  typedef enum int {
    CF_DOUT  = 0,
    CF_DIR   = 1,
    CF_IEN   = 2,
    CF_IMSK  = 3,
    CF_ITYP  = 4,
    CF_IPOL  = 5,
    CF_IDB   = 6,
    CF_IDUAL = 7
  } cfg_e;

  localparam logic [ADDR_W-1:0] OFS_DIR_ST  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h78;
  localparam logic [ADDR_W-1:0] OFS_PINS    = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_COMB    = 8'ha0;
  localparam logic [ADDR_W-1:0] OFS_DUAL_ST = 8'hb8;

  // set address of settings word idx; its clear address is 4 above
  function automatic logic [ADDR_W-1:0] cfg_set_ofs(input int idx);
    logic [ADDR_W-1:0] r;
    case (idx)
      0:       r = 8'h00;
      1:       r = 8'h10;
      2:       r = 8'h20;
      3:       r = 8'h30;
      4:       r = 8'h40;
      5:       r = 8'h50;
      6:       r = 8'h60;
      default: r = 8'hb0;
    endcase
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_clr_ofs(input int idx);
    return cfg_set_ofs(idx) + 8'h04;
  endfunction

  // edge event selection; dual-edge overrides trigger kind and polarity
  function automatic logic edge_hit(input logic dual, input logic typ,
                                    input logic pol, input logic rise,
                                    input logic fall);
    return dual ? (rise | fall) : (typ & (pol ? rise : fall));
  endfunction

  function automatic logic is_edge_mode(input logic dual, input logic typ);
    return dual | typ;
  endfunction

  function automatic logic level_hit(input logic pol, input logic lvl);
    return pol ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs import gpio_pkg::*; #(
  parameter int NL = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [NCFG-1:0][NL-1:0]    cfg,
  output logic                       comb_en,
  output logic [NL-1:0]              ack
);
  for (genvar g = 0; g < NCFG; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[g] <= '0;
      else if (wr && addr == cfg_set_ofs(g))
        cfg[g] <= cfg[g] | wdata[NL-1:0];
      else if (wr && addr == cfg_clr_ofs(g))
        cfg[g] <= cfg[g] & ~wdata[NL-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      comb_en <= 1'b0;
    else if (wr && addr == OFS_COMB)
      comb_en <= wdata[0];
  end

  assign ack = (wr && addr == OFS_ACK) ? wdata[NL-1:0] : '0;
endmodule

// File: rtl/gpio_line_in.sv
module gpio_line_in #(
  parameter int DB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic db_on,
  output logic level
);
  localparam int CW = $clog2(DB_CYCLES + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      cnt   <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (!db_on) begin
        level <= s2;
        cnt   <= '0;
      end else if (s2 == level) begin
        cnt <= '0;
      end else if (cnt == CW'(DB_CYCLES - 1)) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_line_evt.sv
module gpio_line_evt import gpio_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic en,
  input  logic typ,
  input  logic pol,
  input  logic dual,
  input  logic ack,
  output logic evt,
  output logic raw
);
  logic prev, held;
  logic rise, fall;

  assign rise = level & ~prev;
  assign fall = ~level & prev;
  assign evt  = edge_hit(dual, typ, pol, rise, fall);

  // a new event in the acknowledge cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      held <= 1'b0;
    end else begin
      prev <= level;
      held <= (held & ~ack) | (evt & en);
    end
  end

  assign raw = is_edge_mode(dual, typ) ? held : level_hit(pol, level);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_pkg::*; #(
  parameter int NL        = 32,
  parameter int DB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NL-1:0]     pin_in,
  output logic [NL-1:0]     pin_out,
  output logic [NL-1:0]     pin_oe,
  output logic              irq_out
);
  logic [NCFG-1:0][NL-1:0] cfg;
  logic                    comb_en;
  logic [NL-1:0]           ack;
  logic [NL-1:0]           lvl;
  logic [NL-1:0]           evt;
  logic [NL-1:0]           raw;
  logic [NL-1:0]           sts;
  logic [NL-1:0]           dual;
  logic [31:0]             rmux;

  gpio_regs #(.NL(NL)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg(cfg), .comb_en(comb_en), .ack(ack)
  );

  for (genvar i = 0; i < NL; i++) begin : g_line
    gpio_line_in #(.DB_CYCLES(DB_CYCLES)) in_i (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
      .db_on(cfg[CF_IDB][i]), .level(lvl[i])
    );
    gpio_line_evt evt_i (
      .clk(clk), .rst_n(rst_n), .level(lvl[i]),
      .en(cfg[CF_IEN][i]), .typ(cfg[CF_ITYP][i]), .pol(cfg[CF_IPOL][i]),
      .dual(cfg[CF_IDUAL][i]), .ack(ack[i]), .evt(evt[i]), .raw(raw[i])
    );
  end

  assign dual    = cfg[CF_IDUAL];
  assign sts     = raw & cfg[CF_IEN] & ~cfg[CF_IMSK];
  assign irq_out = comb_en & (|sts);
  assign pin_out = cfg[CF_DOUT];
  assign pin_oe  = cfg[CF_DIR];

  always_comb begin
    case (bus_addr)
      OFS_DIR_ST:  rmux = 32'(cfg[CF_DIR]);
      OFS_DUAL_ST: rmux = 32'(dual);
      OFS_STATUS:  rmux = 32'(sts);
      OFS_PINS:    rmux = 32'(lvl);
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rmux;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk import gpio_pkg::*; #(
  parameter int NL = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NL-1:0]     pin_out,
  input logic [NL-1:0]     pin_oe,
  input logic              irq_out,
  input logic [NL-1:0]     sts,
  input logic [NL-1:0]     dual
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq_out));

  // R2
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10) |=>
      ((pin_oe & $past(bus_wdata[NL-1:0])) == $past(bus_wdata[NL-1:0])));

  // R2
  dout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04) |=> ((pin_out & $past(bus_wdata[NL-1:0])) == '0));

  // R7
  dual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hb0) |=>
      ((dual & $past(bus_wdata[NL-1:0])) == $past(bus_wdata[NL-1:0])));

  // R9
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h24) |=> ((sts & $past(bus_wdata[NL-1:0])) == '0));

  // R10
  comb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_COMB && !bus_wdata[0]) |=> !irq_out);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NL(NL)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .sts(sts), .dual(dual)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  localparam int NL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  event rd_done;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NL(NL), .DB_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // monitor: compares each registered read result against the queued expectation
  initial forever begin
    @(rd_done);
    begin
      exp_t it;
      it = q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // driver: issues a read and pushes the expected value
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    q.push_back('{e, t});
    -> rd_done;
    #0.1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    rd(8'h18, 32'h0, "R1 direction readback");
    rd(8'hb8, 32'h0, "R1 dual-edge readback");
    rd(8'h70, 32'h0, "R1 status");

    // R2 set/clear semantics
    wr(8'h00, 32'h0000_00f0);
    chk("R2 dout set", 32'(pin_out), 32'h0000_00f0);
    wr(8'h04, 32'h0000_0030);
    chk("R2 dout clear", 32'(pin_out), 32'h0000_00c0);
    wr(8'h00, 32'h0);
    chk("R2 dout zero write keeps", 32'(pin_out), 32'h0000_00c0);
    wr(8'h10, 32'hff00_0000);
    rd(8'h18, 32'hff00_0000, "R2 direction set");
    wr(8'h14, 32'h0f00_0000);
    rd(8'h18, 32'hf000_0000, "R2 direction clear");
    chk("R2 pin_oe", 32'(pin_oe), 32'hf000_0000);

    // R3 pin levels
    pins = 32'ha5a5_1234; settle(6);
    rd(8'h80, 32'ha5a5_1234, "R3 pin levels");
    pins = 32'h0; settle(6);
    rd(8'h80, 32'h0, "R3 pins cleared");

    // R4 debounce on line 0
    wr(8'h60, 32'h1);
    pins[0] = 1'b1; settle(2); pins[0] = 1'b0; settle(8);
    rd(8'h80, 32'h0, "R4 short pulse rejected");
    pins[0] = 1'b1; settle(12);
    rd(8'h80, 32'h1, "R4 stable level accepted");
    pins[0] = 1'b0; settle(12);
    rd(8'h80, 32'h0, "R4 stable low accepted");
    wr(8'h64, 32'h1);

    wr(8'ha0, 32'h1);
    chk("R10 idle irq", 32'(irq_out), 32'h0);

    // R5 rising on line 1
    wr(8'h40, 32'h2); wr(8'h50, 32'h2); wr(8'h20, 32'h2);
    pins[1] = 1'b1; settle(6);
    rd(8'h70, 32'h2, "R5 rising event");
    chk("R10 irq with pending", 32'(irq_out), 32'h1);
    pins[1] = 1'b0; settle(6);
    rd(8'h70, 32'h2, "R5 event held after pin drops");
    wr(8'h78, 32'h2);
    rd(8'h70, 32'h0, "R8 acknowledge clears");
    chk("R10 irq after ack", 32'(irq_out), 32'h0);

    // R5 falling on line 2
    wr(8'h40, 32'h4); wr(8'h20, 32'h4);
    pins[2] = 1'b1; settle(6);
    rd(8'h70, 32'h0, "R5 rise ignored by falling line");
    pins[2] = 1'b0; settle(6);
    rd(8'h70, 32'h4, "R5 falling event");
    wr(8'h78, 32'h4);
    rd(8'h70, 32'h0, "R8 ack falling");
    wr(8'h24, 32'h4);

    // R6 level high on line 3
    wr(8'h50, 32'h8); wr(8'h20, 32'h8);
    rd(8'h70, 32'h0, "R6 level high idle");
    pins[3] = 1'b1; settle(6);
    rd(8'h70, 32'h8, "R6 level high pending");
    wr(8'h78, 32'h8);
    rd(8'h70, 32'h8, "R6 ack no effect on level");
    pins[3] = 1'b0; settle(6);
    rd(8'h70, 32'h0, "R6 level follows input");
    wr(8'h24, 32'h8);

    // R6 level low on line 4
    wr(8'h20, 32'h10);
    rd(8'h70, 32'h10, "R6 level low pending");
    pins[4] = 1'b1; settle(6);
    rd(8'h70, 32'h0, "R6 level low released");
    wr(8'h24, 32'h10);
    pins[4] = 1'b0; settle(6);

    // R7 dual edge on line 5 (trigger 0, polarity 0 would be level low)
    wr(8'hb0, 32'h20);
    rd(8'hb8, 32'h20, "R7 dual readback");
    wr(8'h20, 32'h20);
    rd(8'h70, 32'h0, "R7 dual overrides level low");
    pins[5] = 1'b1; settle(6);
    rd(8'h70, 32'h20, "R7 dual rising");
    wr(8'h78, 32'h20);
    rd(8'h70, 32'h0, "R7 ack");
    pins[5] = 1'b0; settle(6);
    rd(8'h70, 32'h20, "R7 dual falling");
    wr(8'h78, 32'h20);
    wr(8'hb4, 32'h20);
    rd(8'hb8, 32'h0, "R7 dual cleared");
    rd(8'h70, 32'h20, "R7 level low restored");
    wr(8'h24, 32'h20);

    // R8 acknowledge coinciding with a new edge on line 1
    pins[1] = 1'b1; settle(6);
    rd(8'h70, 32'h2, "R8 setup held");
    pins[1] = 1'b0; settle(6);
    pins[1] = 1'b1;
    settle(3);
    wr(8'h78, 32'h2);
    rd(8'h70, 32'h2, "R8 new edge wins over ack");
    wr(8'h78, 32'h2);
    rd(8'h70, 32'h0, "R8 plain ack");

    // R9 mask hides without clearing
    pins[1] = 1'b0; settle(6);
    pins[1] = 1'b1; settle(6);
    wr(8'h30, 32'h2);
    rd(8'h70, 32'h0, "R9 masked hidden");
    chk("R9 irq masked", 32'(irq_out), 32'h0);
    wr(8'h34, 32'h2);
    rd(8'h70, 32'h2, "R9 unmask restores held");
    chk("R9 irq unmasked", 32'(irq_out), 32'h1);

    // R10 combined gate
    wr(8'ha0, 32'h0);
    chk("R10 gate closed", 32'(irq_out), 32'h0);
    rd(8'h70, 32'h2, "R10 status kept while gated");
    wr(8'ha0, 32'h1);
    chk("R10 gate open", 32'(irq_out), 32'h1);
    wr(8'h78, 32'h2);

    // R9 disabled line records nothing
    wr(8'h24, 32'h2);
    pins[1] = 1'b0; settle(6);
    pins[1] = 1'b1; settle(6);
    rd(8'h70, 32'h0, "R9 disabled no status");
    wr(8'h20, 32'h2);
    rd(8'h70, 32'h0, "R9 no event recorded while disabled");
    chk("R9 irq none", 32'(irq_out), 32'h0);

    settle(2);
    finish_run();
  end
endmodule